// File: doc/BRIEF.md
# Full-Duplex Framed Synchronous Serial Port

This block is the data path of a full-duplex synchronous serial port. The transmit side takes words from a holding register, moves each one into a shifter, and sends it out MSB first on `dx`, one bit per serial clock period. The receive side shifts `dr` into a second shifter. When a word is complete, it moves to a receive holding register, right-justified with zero fill. The two directions run independently. Each has its own bit clock and frame sync, which come in as plain inputs and are oversampled by the system clock `clk`. Both directions share one configuration: word length, number of words per frame, data delay after the frame sync, which clock edge is used, and frame-sync polarity.

Both holding registers are double buffered. Each has a ready flag, and a one-cycle event pulse marks the cycle in which that flag sets. These events are meant to trigger DMA transfers or interrupts. A simple write strobe loads the transmit holding register, and a read strobe acknowledges the receive holding register. If a frame sync starts a new frame while the current frame still has words left, a sticky error flag sets for that direction.

Top module: `serial_port_duplex`

## Requirements
- R1: `cfg_wlen` selects the bits per word: code 0 gives 8 bits, 1 gives 12, 2 gives 16, 3 gives 20 and 4 gives 24. Codes 5, 6 and 7 all give 32.
- R2: A frame carries `cfg_frlen`+1 words, from 1 to 128, and then the direction goes idle until the next frame start.
- R3: Transmit shifts one bit per drive edge, MSB first. `dx` is a register that updates one `clk` after the edge is seen, and it is 0 during delay bits and while idle.
- R4: Receive takes one bit per sample edge. A finished word appears in `rx_data` right-justified, with the bits above the word length at zero.
- R5: `cfg_delay` (0 to 3) is the number of bit periods between the frame start and the first data bit. A value of 0 puts the first data bit in the same bit period as the frame sync.
- R6: With `cfg_clk_pol`=0, transmit drives on the rising edge of `tx_sclk` and receive samples on the falling edge of `rx_sclk`. With 1, both edges are swapped. `cfg_fs_pol`=1 makes the frame syncs active low. A frame starts at the first relevant edge where the frame sync is active after it was inactive at the previous such edge.
- R7: `rrdy` sets in the cycle a word enters the receive holding register. `rd_en` clears it, but if both happen in the same cycle, the new word wins.
- R8: `xrdy` is 1 after reset. It sets again when the holding register is copied into the shifter, which happens at the first bit of every word. `wr_en` clears it and loads `wr_data`, and a write wins over a copy in the same cycle.
- R9: `revt` and `xevt` are single-cycle pulses, issued in the cycle the receive holding register fills and in the cycle the transmit holding register is copied.
- R10: A frame start that arrives while a frame is still active sets `rx_sync_err` or `tx_sync_err` for that direction. The flag stays set until reset, and the new frame restarts from word 0.
- R11: Reset (synchronous, active high) clears `dx`, `rrdy`, `revt`, `xevt`, both error flags and `rx_data`, and sets `xrdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial clocks |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wlen | input | 3 | Word length code |
| cfg_frlen | input | 7 | Words per frame minus one |
| cfg_delay | input | 2 | Data delay in bit periods |
| cfg_clk_pol | input | 1 | Clock edge select |
| cfg_fs_pol | input | 1 | Frame sync active low when 1 |
| tx_sclk | input | 1 | Transmit bit clock |
| tx_fs | input | 1 | Transmit frame sync |
| dx | output | 1 | Serial data out |
| rx_sclk | input | 1 | Receive bit clock |
| rx_fs | input | 1 | Receive frame sync |
| dr | input | 1 | Serial data in |
| wr_en | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | 32 | Transmit word, right-justified |
| rd_en | input | 1 | Read acknowledge for the receive holding register |
| rx_data | output | 32 | Receive holding register |
| rrdy | output | 1 | Receive word waiting |
| xrdy | output | 1 | Transmit holding register free |
| revt | output | 1 | Receive event pulse |
| xevt | output | 1 | Transmit event pulse |
| rx_sync_err | output | 1 | Receive frame-sync error, sticky |
| tx_sync_err | output | 1 | Transmit frame-sync error, sticky |

## Verification
The bench sweeps every word length, every data delay, one- and three-word frames and all four polarity combinations. It also runs one 128-word frame. On the receive side, the bench serializes its own words onto `dr` and checks them. On the transmit side, it rebuilds `dx` bit by bit, so an LSB-first shifter or a zero-fill mistake cannot hide behind a loopback. Other errors it catches:
- An off-by-one in the delay count shifts every transmitted bit and garbles every received word.
- A miscounted frame length either drops the last word or sends an extra one.
- Events that fire on the wrong bit, or last longer than one cycle, show up in per-slot checks.
- A frame sync repeated mid-frame must raise both error flags, and the flags must not rise at the normal end of a frame.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int MAX_W = 32;
  localparam int CNT_W = $clog2(MAX_W) + 1;

  // word length code to bit count; codes above 4 select the full width
  function automatic logic [CNT_W-1:0] word_bits(input logic [2:0] code);
    case (code)
      3'd0:    word_bits = CNT_W'(8);
      3'd1:    word_bits = CNT_W'(12);
      3'd2:    word_bits = CNT_W'(16);
      3'd3:    word_bits = CNT_W'(20);
      3'd4:    word_bits = CNT_W'(24);
      default: word_bits = CNT_W'(MAX_W);
    endcase
  endfunction
endpackage

// File: rtl/ssp_edge_sel.sv
module ssp_edge_sel #(
  parameter bit DRIVE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic fs_i,
  input  logic clk_pol_i,
  input  logic fs_pol_i,
  output logic edge_o,
  output logic fs_o
);
  logic sclk_q;
  logic rise, fall, use_fall;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk_i;
  end

  always_comb begin
    rise     = sclk_i & ~sclk_q;
    fall     = ~sclk_i & sclk_q;
    use_fall = DRIVE ? clk_pol_i : ~clk_pol_i;
    edge_o   = use_fall ? fall : rise;
    fs_o     = fs_i ^ fs_pol_i;
  end
endmodule

// File: rtl/ssp_frame_ctl.sv
module ssp_frame_ctl #(
  parameter int FRAME_W = 7,
  parameter int DLY_W   = 2,
  parameter int CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               edge_i,
  input  logic               fs_i,
  input  logic [CNT_W-1:0]   wbits_i,
  input  logic [FRAME_W-1:0] frlen_i,
  input  logic [DLY_W-1:0]   dly_i,
  output logic               bit_o,
  output logic               first_o,
  output logic               last_o,
  output logic               err_o
);
  logic               fs_prev, active;
  logic [DLY_W-1:0]   dly_cnt, dly_eff;
  logic [CNT_W-1:0]   bit_cnt, bit_eff;
  logic [FRAME_W-1:0] word_cnt, word_eff;
  logic               start, go;

  always_comb begin
    start    = edge_i & fs_i & ~fs_prev;
    go       = start | (edge_i & active);
    dly_eff  = start ? dly_i : dly_cnt;
    bit_eff  = start ? '0 : bit_cnt;
    word_eff = start ? '0 : word_cnt;
    bit_o    = go && (dly_eff == '0);
    first_o  = bit_o && (bit_eff == '0);
    last_o   = bit_o && (bit_eff == wbits_i - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_prev  <= 1'b0;
      active   <= 1'b0;
      dly_cnt  <= '0;
      bit_cnt  <= '0;
      word_cnt <= '0;
      err_o    <= 1'b0;
    end else begin
      if (edge_i) fs_prev <= fs_i;
      if (start && active) err_o <= 1'b1;
      if (go) begin
        active   <= 1'b1;
        bit_cnt  <= bit_eff;
        word_cnt <= word_eff;
        if (!bit_o) begin
          dly_cnt <= dly_eff - 1'b1;
        end else begin
          dly_cnt <= '0;
          if (last_o) begin
            bit_cnt <= '0;
            if (word_eff == frlen_i) active <= 1'b0;
            else                     word_cnt <= word_eff + 1'b1;
          end else begin
            bit_cnt <= bit_eff + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/serial_port_duplex.sv
module serial_port_duplex
  import ssp_pkg::*;
#(
  parameter int FRAME_W = 7,
  parameter int DLY_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         cfg_wlen,
  input  logic [FRAME_W-1:0] cfg_frlen,
  input  logic [DLY_W-1:0]   cfg_delay,
  input  logic               cfg_clk_pol,
  input  logic               cfg_fs_pol,
  input  logic               tx_sclk,
  input  logic               tx_fs,
  output logic               dx,
  input  logic               rx_sclk,
  input  logic               rx_fs,
  input  logic               dr,
  input  logic               wr_en,
  input  logic [MAX_W-1:0]   wr_data,
  input  logic               rd_en,
  output logic [MAX_W-1:0]   rx_data,
  output logic               rrdy,
  output logic               xrdy,
  output logic               revt,
  output logic               xevt,
  output logic               rx_sync_err,
  output logic               tx_sync_err
);
  logic [CNT_W-1:0] wbits;
  logic             tx_edge, tx_fs_act, rx_edge, rx_fs_act;
  logic             tx_bit, tx_first, tx_last;
  logic             rx_bit, rx_first, rx_last;
  logic [MAX_W-1:0] tx_hold, tx_sr, tx_aligned;
  logic [MAX_W-1:0] rx_sr;

  assign wbits = word_bits(cfg_wlen);

  ssp_edge_sel #(.DRIVE(1'b1)) u_tx_edge (
    .clk(clk), .rst(rst), .sclk_i(tx_sclk), .fs_i(tx_fs),
    .clk_pol_i(cfg_clk_pol), .fs_pol_i(cfg_fs_pol),
    .edge_o(tx_edge), .fs_o(tx_fs_act)
  );

  ssp_edge_sel #(.DRIVE(1'b0)) u_rx_edge (
    .clk(clk), .rst(rst), .sclk_i(rx_sclk), .fs_i(rx_fs),
    .clk_pol_i(cfg_clk_pol), .fs_pol_i(cfg_fs_pol),
    .edge_o(rx_edge), .fs_o(rx_fs_act)
  );

  ssp_frame_ctl #(.FRAME_W(FRAME_W), .DLY_W(DLY_W), .CNT_W(CNT_W)) u_tx_frame (
    .clk(clk), .rst(rst), .edge_i(tx_edge), .fs_i(tx_fs_act),
    .wbits_i(wbits), .frlen_i(cfg_frlen), .dly_i(cfg_delay),
    .bit_o(tx_bit), .first_o(tx_first), .last_o(tx_last), .err_o(tx_sync_err)
  );

  ssp_frame_ctl #(.FRAME_W(FRAME_W), .DLY_W(DLY_W), .CNT_W(CNT_W)) u_rx_frame (
    .clk(clk), .rst(rst), .edge_i(rx_edge), .fs_i(rx_fs_act),
    .wbits_i(wbits), .frlen_i(cfg_frlen), .dly_i(cfg_delay),
    .bit_o(rx_bit), .first_o(rx_first), .last_o(rx_last), .err_o(rx_sync_err)
  );

  // left-align the holding word so the MSB of the active width sits on top
  assign tx_aligned = tx_hold << (CNT_W'(MAX_W) - wbits);

  // transmit side
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_hold <= '0;
      tx_sr   <= '0;
      dx      <= 1'b0;
      xrdy    <= 1'b1;
      xevt    <= 1'b0;
    end else begin
      xevt <= 1'b0;
      if (tx_edge) begin
        if (tx_first) begin
          dx    <= tx_aligned[MAX_W-1];
          tx_sr <= tx_aligned << 1;
          xrdy  <= 1'b1;
          xevt  <= 1'b1;
        end else if (tx_bit) begin
          dx    <= tx_sr[MAX_W-1];
          tx_sr <= tx_sr << 1;
        end else begin
          dx <= 1'b0;
        end
      end
      if (wr_en) begin
        tx_hold <= wr_data;
        xrdy    <= 1'b0;
      end
    end
  end

  // receive side
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sr   <= '0;
      rx_data <= '0;
      rrdy    <= 1'b0;
      revt    <= 1'b0;
    end else begin
      revt <= 1'b0;
      if (rx_bit) begin
        if (rx_first) rx_sr <= {{(MAX_W-1){1'b0}}, dr};
        else          rx_sr <= {rx_sr[MAX_W-2:0], dr};
      end
      if (rx_last) begin
        rx_data <= {rx_sr[MAX_W-2:0], dr};
        rrdy    <= 1'b1;
        revt    <= 1'b1;
      end else if (rd_en) begin
        rrdy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_port_duplex_chk.sv
module serial_port_duplex_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic rd_en,
  input logic rrdy,
  input logic xrdy,
  input logic revt,
  input logic xevt,
  input logic rx_sync_err,
  input logic tx_sync_err
);
  // R7
  rx_evt_sets_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    revt |-> rrdy);

  // R7
  rd_clears_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !revt) |=> (!rrdy || revt));

  // R8
  wr_clears_xrdy_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !xrdy);

  // R8
  tx_evt_sets_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    (xevt && !$past(wr_en)) |-> xrdy);

  // R9
  revt_single_chk: assert property (@(posedge clk) disable iff (rst)
    revt |=> !revt);

  // R9
  xevt_single_chk: assert property (@(posedge clk) disable iff (rst)
    xevt |=> !xevt);

  // R10
  rx_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    rx_sync_err |=> rx_sync_err);

  // R10
  tx_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    tx_sync_err |=> tx_sync_err);
endmodule

bind serial_port_duplex serial_port_duplex_chk u_chk (.*);

// File: tb/test_serial_port_duplex.sv
module test_serial_port_duplex;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cfg_wlen = 3'd0;
  logic [6:0]  cfg_frlen = 7'd0;
  logic [1:0]  cfg_delay = 2'd0;
  logic        cfg_clk_pol = 1'b0;
  logic        cfg_fs_pol = 1'b0;
  logic        sclk = 1'b0;
  logic        fs = 1'b0;
  logic        dr = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic        dx, rrdy, xrdy, revt, xevt, rx_sync_err, tx_sync_err;
  logic [31:0] rx_data;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [31:0] txw [0:127];
  logic [31:0] rxw [0:127];
  int tx_next, nwords;

  always #10 clk = ~clk;

  serial_port_duplex i_serial_port_duplex (
    .clk(clk), .rst(rst), .cfg_wlen(cfg_wlen), .cfg_frlen(cfg_frlen),
    .cfg_delay(cfg_delay), .cfg_clk_pol(cfg_clk_pol), .cfg_fs_pol(cfg_fs_pol),
    .tx_sclk(sclk), .tx_fs(fs), .dx(dx), .rx_sclk(sclk), .rx_fs(fs), .dr(dr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rx_data(rx_data),
    .rrdy(rrdy), .xrdy(xrdy), .revt(revt), .xevt(xevt),
    .rx_sync_err(rx_sync_err), .tx_sync_err(tx_sync_err)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int nbits(input int code);
    return (code >= 5) ? 32 : 8 + 4 * code;
  endfunction

  function automatic logic [31:0] wmask(input int nb);
    logic [63:0] m;
    m = (64'd1 << nb) - 64'd1;
    return m[31:0];
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    wr_en = 1'b0;
    rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // one bit period: drive edge, then sample edge; checks only when chk_en
  task automatic slot(input bit fs_act, input bit drb, input bit chk_en,
                      input bit exp_xevt, input bit exp_dx,
                      input bit exp_revt, input logic [31:0] exp_word);
    bit wrote;
    wrote = 1'b0;
    sclk = cfg_clk_pol ? 1'b0 : 1'b1;
    fs = fs_act ^ cfg_fs_pol;
    dr = drb;
    wr_en = 1'b0;
    rd_en = 1'b0;
    @(negedge clk);
    if (chk_en) chk("R9 xevt on word start", {31'b0, xevt}, {31'b0, exp_xevt});
    @(negedge clk);
    sclk = cfg_clk_pol ? 1'b1 : 1'b0;
    if (chk_en) chk("R3 dx MSB first", {31'b0, dx}, {31'b0, exp_dx});
    @(negedge clk);
    if (chk_en) begin
      chk("R9 revt on word end", {31'b0, revt}, {31'b0, exp_revt});
      chk("R7 rrdy", {31'b0, rrdy}, {31'b0, exp_revt});
      if (exp_revt) chk("R4 rx word right-justified", rx_data, exp_word);
      if (exp_xevt) chk("R8 xrdy after copy", {31'b0, xrdy}, 32'd1);
    end
    rd_en = 1'b1;
    if (xrdy && tx_next < nwords) begin
      wr_en = 1'b1;
      wr_data = txw[tx_next];
      tx_next++;
      wrote = 1'b1;
    end
    @(negedge clk);
    if (chk_en && wrote) chk("R8 write clears xrdy", {31'b0, xrdy}, 32'd0);
  endtask

  task automatic run_frame(input int w, input int fl, input int dl,
                           input bit cp, input bit fp, input int seed);
    int nb, total;
    nb = nbits(w);
    nwords = fl + 1;
    // configuration change with the lines at their new idle levels
    @(negedge clk);
    cfg_wlen = 3'(w);
    cfg_frlen = 7'(fl);
    cfg_delay = 2'(dl);
    cfg_clk_pol = cp;
    cfg_fs_pol = fp;
    sclk = cp ? 1'b1 : 1'b0;
    fs = fp;
    wr_en = 1'b0;
    rd_en = 1'b0;
    for (int k = 0; k < nwords; k++) begin
      txw[k] = 32'(seed * 32'h9E3779B9 + k * 32'h7F4A7C15) & wmask(nb);
      rxw[k] = 32'((seed + 17) * 32'h85EBCA6B ^ k * 32'hC2B2AE35) & wmask(nb);
    end
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = txw[0];
    tx_next = 1;
    @(negedge clk);
    wr_en = 1'b0;
    // R1 R2 R5 R6: slot count follows from delay, words and word length
    total = dl + nwords * nb;
    for (int s = 0; s < total + 2; s++) begin
      if (s >= dl && s < total) begin
        int idx, k, b;
        idx = s - dl;
        k = idx / nb;
        b = nb - 1 - (idx % nb);
        slot(s == 0, rxw[k][b], 1'b1, b == nb - 1, txw[k][b], b == 0, rxw[k]);
      end else begin
        slot(s == 0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
      end
    end
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    // R11 reset state
    chk("R11 dx", {31'b0, dx}, 32'd0);
    chk("R11 rrdy", {31'b0, rrdy}, 32'd0);
    chk("R11 xrdy", {31'b0, xrdy}, 32'd1);
    chk("R11 revt/xevt", {30'b0, revt, xevt}, 32'd0);
    chk("R11 errors", {30'b0, rx_sync_err, tx_sync_err}, 32'd0);
    chk("R11 rx_data", rx_data, 32'd0);

    // R1 R5 R6 sweep of word length, delay, frame length and polarities
    for (int w = 0; w < 6; w++)
      for (int dl = 0; dl < 4; dl++)
        for (int f = 0; f < 2; f++) begin
          int p;
          p = (w + dl + f) % 4;
          run_frame(w, f * 2, dl, p[0], p[1], w * 31 + dl * 7 + f);
        end
    // R1 reserved code behaves as 32 bits
    run_frame(7, 1, 1, 1'b0, 1'b1, 99);
    // R2 longest frame
    run_frame(0, 127, 0, 1'b1, 1'b0, 123);
    // R10 no error after complete frames
    chk("R10 no error on clean frames", {30'b0, rx_sync_err, tx_sync_err}, 32'd0);

    // R10 frame sync repeated mid-frame
    run_frame(0, 1, 0, 1'b0, 1'b0, 5);
    nwords = 0;
    slot(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    for (int s = 0; s < 3; s++) slot(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    chk("R10 no error before resync", {30'b0, rx_sync_err, tx_sync_err}, 32'd0);
    slot(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    slot(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    chk("R10 both errors set", {30'b0, rx_sync_err, tx_sync_err}, 32'd3);
    for (int s = 0; s < 20; s++) slot(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    chk("R10 errors sticky", {30'b0, rx_sync_err, tx_sync_err}, 32'd3);
    do_reset();
    @(negedge clk);
    chk("R11 reset clears errors", {30'b0, rx_sync_err, tx_sync_err}, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        fails++;
        $display("FAIL watchdog: got %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end
endmodule